// File: doc/BRIEF.md
# Framed Serial Transmit Sequencer

This block sequences the transmit side of a synchronous serial link that carries flag-delimited frames protected by a 16-bit CRC. A write strobe with a byte count between 1 and 253 starts a frame. The sequencer then sends an opening flag, fetches each payload byte from a shared buffer through a request/acknowledge memory port, and hands each byte to an external bit serializer. The serializer asks for the next byte with a one-cycle pulse. Each payload byte is also fed to an external CRC engine, and the two CRC result bytes are appended before the closing flag. When the frame is done, the sequencer overwrites the length location with all-ones and pulses the interrupt.

The sequencer also keeps a clock-status location in the same memory. That location holds 0x00 while the bit clock is absent and 0xFF while it is present. The sequencer rewrites it whenever the clock changes, and again, quietly, after software writes to it. If the clock disappears during a frame, the frame is dropped.

The memory is a 256-byte half buffer. Payload sits at addresses 0 upward, the clock status at 0xFE and the length/status at 0xFF.

Top module: `ftx_ctrl`

## Requirements
- R1: A length write (`len_wr`) with a value from 1 to 253 starts a frame when the bit clock is present. The first byte out is the flag 0x7E with `ser_flag`=1. It is followed by payload bytes read from addresses 0 to length-1 in ascending order, each with `ser_flag`=0.
- R2: Length values 0x00, 0xFE and 0xFF are ignored. Any length write made while a frame is in progress is also ignored.
- R3: The opening flag is presented (`ser_wr` pulse) two clock edges after the length strobe. Each later byte is presented only after a `ser_next` pulse for the previous one.
- R4: A memory access holds `mem_req`, `mem_addr` and `mem_rwn` (1 = read) steady until `mem_ack`. Read data is taken in the acknowledge cycle.
- R5: `crc_clr` pulses with the opening flag, and `crc_en` pulses exactly once per payload byte with `crc_din` equal to that byte. After the last payload byte, the sequencer waits for `crc_valid` and sends `crc_val[15:8]` and then `crc_val[7:0]` with `ser_flag`=0. These two bytes are never fed to the CRC engine.
- R6: The closing flag 0x7E (`ser_flag`=1) follows the CRC bytes. After its `ser_next`, 0xFF is written to address 0xFF. The acknowledge of that write produces a one-cycle `irq` pulse, and the sequencer returns to idle.
- R7: The clock status starts as 0x00 after reset. Whenever `bclk_ok` differs from the last status written, 0xFF (present) or 0x00 (absent) is written to address 0xFE, and its acknowledge produces a one-cycle `irq`.
- R8: A `clk_wr` strobe causes the true status to be rewritten at 0xFE without an interrupt. If a genuine clock change is pending at the same time, the interrupt is still raised, exactly once.
- R9: A pending clock-status write is served before a frame starts. An accepted length is held while the bit clock is absent and starts the frame once the clock is present.
- R10: If `bclk_ok` falls before the final write, the frame is abandoned. No further byte is presented and 0xFF is not written to 0xFF; the status update of R7 follows.
- R11: During and after reset, `mem_req`, `ser_wr`, `crc_clr`, `crc_en` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| len_wr | input | 1 | Strobe: CPU wrote the length/status location |
| len_data | input | 8 | Value written with `len_wr` |
| clk_wr | input | 1 | Strobe: CPU wrote the clock-status location |
| bclk_ok | input | 1 | Bit clock present |
| mem_req | output | 1 | Memory access request |
| mem_rwn | output | 1 | 1 = read, 0 = write |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory access acknowledge |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` |
| ser_wr | output | 1 | Byte strobe to serializer |
| ser_flag | output | 1 | Byte is a flag, not data |
| ser_data | output | 8 | Byte to serializer |
| ser_next | input | 1 | Serializer ready for the next byte |
| crc_clr | output | 1 | Clear CRC engine |
| crc_en | output | 1 | Feed `crc_din` into CRC engine |
| crc_din | output | 8 | Byte for CRC engine |
| crc_valid | input | 1 | CRC result is settled |
| crc_val | input | 16 | CRC result |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Two pairs of events are made to coincide. In the first, a length is accepted while the bit clock is absent, and the clock then returns. This makes a status write and a frame start due in the same idle cycle. The check is that the first memory write goes to 0xFE and that a complete frame follows. In the second, a `clk_wr` strobe is driven in the same cycle that `bclk_ok` falls. The check is that exactly one interrupt is raised and that 0x00 ends up at 0xFE.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CLKW, ST_WNXT, ST_RD, ST_CRCW, ST_DONE
  } ftx_state_t;

  typedef enum logic [1:0] {
    PH_BODY, PH_CRCLO, PH_CLOSE, PH_END
  } ftx_phase_t;
endpackage

// File: rtl/ftx_lenfilt.sv
module ftx_lenfilt #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] data,
  input  logic          accept,
  input  logic          take,
  output logic          pend,
  output logic [AW-1:0] len
);
  localparam int MAXV = (1 << AW) - 3;

  logic in_range;
  assign in_range = (data != '0) && (int'(data) <= MAXV);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      len  <= '0;
    end else if (wr && accept && in_range) begin
      pend <= 1'b1;
      len  <= AW'(data);
    end else if (take) begin
      pend <= 1'b0;
    end
  end

  // R2: a held length is always a legal count
  a_r2_pend_range: assert property (@(posedge clk) disable iff (rst)
    pend |-> (len != '0) && (int'(len) <= MAXV));
endmodule

// File: rtl/ftx_clkstat.sv
module ftx_clkstat (
  input  logic clk,
  input  logic rst,
  input  logic bclk_ok,
  input  logic cpu_wr,
  input  logic done,
  input  logic done_val,
  output logic need,
  output logic val,
  output logic quiet
);
  logic shown_q;
  logic fix_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shown_q <= 1'b0;
      fix_q   <= 1'b0;
    end else begin
      if (done) shown_q <= done_val;
      if (cpu_wr) fix_q <= 1'b1;
      else if (done) fix_q <= 1'b0;
    end
  end

  always_comb begin
    need  = (bclk_ok != shown_q) || fix_q;
    val   = bclk_ok;
    quiet = (bclk_ok == shown_q);
  end

  // R8: a software rewrite request is never dropped before it is served
  a_r8_fix_kept: assert property (@(posedge clk) disable iff (rst)
    fix_q && !done |=> fix_q);
endmodule

// File: rtl/ftx_seq.sv
module ftx_seq import ftx_pkg::*; #(
  parameter int          DW   = 8,
  parameter int          AW   = 8,
  parameter logic [DW-1:0] FLAG = 8'h7E
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bclk_ok,
  input  logic            start_pend,
  input  logic [AW-1:0]   start_len,
  output logic            start_take,
  output logic            tx_idle,
  input  logic            clk_need,
  input  logic            clk_val,
  input  logic            clk_quiet,
  output logic            clk_done,
  output logic            mem_req,
  output logic            mem_rwn,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  output logic            ser_wr,
  output logic            ser_flag,
  output logic [DW-1:0]   ser_data,
  input  logic            ser_next,
  output logic            crc_clr,
  output logic            crc_en,
  output logic [DW-1:0]   crc_din,
  input  logic            crc_valid,
  input  logic [2*DW-1:0] crc_val,
  output logic            irq
);
  localparam logic [AW-1:0] LEN_ADDR = '1;
  localparam logic [AW-1:0] CLK_ADDR = LEN_ADDR - 1'b1;

  ftx_state_t      state;
  ftx_phase_t      ph;
  logic [AW-1:0]   idx;
  logic [AW-1:0]   len;
  logic [DW-1:0]   crc_lo;
  logic            quiet_q;

  always_comb begin
    start_take = (state == ST_IDLE) && !clk_need && start_pend && bclk_ok;
    tx_idle    = ((state == ST_IDLE) || (state == ST_CLKW)) && !start_take;
    clk_done   = (state == ST_CLKW) && mem_ack;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ph        <= PH_BODY;
      idx       <= '0;
      len       <= '0;
      crc_lo    <= '0;
      quiet_q   <= 1'b0;
      mem_req   <= 1'b0;
      mem_rwn   <= 1'b1;
      mem_addr  <= '0;
      mem_wdata <= '0;
      ser_wr    <= 1'b0;
      ser_flag  <= 1'b0;
      ser_data  <= '0;
      crc_clr   <= 1'b0;
      crc_en    <= 1'b0;
      crc_din   <= '0;
      irq       <= 1'b0;
    end else begin
      ser_wr  <= 1'b0;
      crc_clr <= 1'b0;
      crc_en  <= 1'b0;
      irq     <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (clk_need) begin
            mem_req   <= 1'b1;
            mem_rwn   <= 1'b0;
            mem_addr  <= CLK_ADDR;
            mem_wdata <= {DW{clk_val}};
            quiet_q   <= clk_quiet;
            state     <= ST_CLKW;
          end else if (start_take) begin
            ser_wr   <= 1'b1;
            ser_flag <= 1'b1;
            ser_data <= FLAG;
            crc_clr  <= 1'b1;
            idx      <= '0;
            len      <= start_len;
            ph       <= PH_BODY;
            state    <= ST_WNXT;
          end
        end
        ST_CLKW: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            irq     <= !quiet_q;
            state   <= ST_IDLE;
          end
        end
        ST_WNXT: begin
          if (!bclk_ok) begin
            state <= ST_IDLE;
          end else if (ser_next) begin
            unique case (ph)
              PH_BODY: begin
                if (idx == len) begin
                  state <= ST_CRCW;
                end else begin
                  mem_req  <= 1'b1;
                  mem_rwn  <= 1'b1;
                  mem_addr <= idx;
                  state    <= ST_RD;
                end
              end
              PH_CRCLO: begin
                ser_wr   <= 1'b1;
                ser_flag <= 1'b0;
                ser_data <= crc_lo;
                ph       <= PH_CLOSE;
              end
              PH_CLOSE: begin
                ser_wr   <= 1'b1;
                ser_flag <= 1'b1;
                ser_data <= FLAG;
                ph       <= PH_END;
              end
              PH_END: begin
                mem_req   <= 1'b1;
                mem_rwn   <= 1'b0;
                mem_addr  <= LEN_ADDR;
                mem_wdata <= '1;
                state     <= ST_DONE;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
        ST_RD: begin
          if (!bclk_ok) begin
            mem_req <= 1'b0;
            state   <= ST_IDLE;
          end else if (mem_ack) begin
            mem_req  <= 1'b0;
            ser_wr   <= 1'b1;
            ser_flag <= 1'b0;
            ser_data <= mem_rdata;
            crc_en   <= 1'b1;
            crc_din  <= mem_rdata;
            idx      <= idx + 1'b1;
            state    <= ST_WNXT;
          end
        end
        ST_CRCW: begin
          if (!bclk_ok) begin
            state <= ST_IDLE;
          end else if (crc_valid) begin
            ser_wr   <= 1'b1;
            ser_flag <= 1'b0;
            ser_data <= crc_val[2*DW-1:DW];
            crc_lo   <= crc_val[DW-1:0];
            ph       <= PH_CRCLO;
            state    <= ST_WNXT;
          end
        end
        ST_DONE: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            irq     <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6, R7: an interrupt only follows an acknowledged write
  a_r6_irq_after_write: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mem_req && mem_ack && !mem_rwn));
  // R4: request, address and direction held until acknowledge
  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack && (bclk_ok || !mem_rwn) |=>
      mem_req && $stable(mem_addr) && $stable(mem_rwn));
  // R5: CRC feed only with a data byte, same value
  a_r5_crc_with_data: assert property (@(posedge clk) disable iff (rst)
    crc_en |-> ser_wr && !ser_flag && (crc_din == ser_data));
  // R1: flag-qualified bytes carry the flag pattern
  a_r1_flag_value: assert property (@(posedge clk) disable iff (rst)
    ser_wr && ser_flag |-> ser_data == FLAG);
  // R6: a write to the length location writes all-ones
  a_r6_done_value: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_rwn && (mem_addr == LEN_ADDR) |-> mem_wdata == '1);
  // R10: no byte is presented after the clock is seen absent
  a_r10_no_byte_without_clock: assert property (@(posedge clk) disable iff (rst)
    !bclk_ok |=> !ser_wr);
endmodule

// File: rtl/ftx_ctrl.sv
module ftx_ctrl #(
  parameter int              DW   = 8,
  parameter int              AW   = 8,
  parameter logic [DW-1:0]   FLAG = 8'h7E
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            len_wr,
  input  logic [DW-1:0]   len_data,
  input  logic            clk_wr,
  input  logic            bclk_ok,
  output logic            mem_req,
  output logic            mem_rwn,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  output logic            ser_wr,
  output logic            ser_flag,
  output logic [DW-1:0]   ser_data,
  input  logic            ser_next,
  output logic            crc_clr,
  output logic            crc_en,
  output logic [DW-1:0]   crc_din,
  input  logic            crc_valid,
  input  logic [2*DW-1:0] crc_val,
  output logic            irq
);
  logic          pend;
  logic [AW-1:0] plen;
  logic          take;
  logic          accept;
  logic          need;
  logic          cval;
  logic          quiet;
  logic          cdone;

  ftx_lenfilt #(.DW(DW), .AW(AW)) u_len (
    .clk(clk), .rst(rst), .wr(len_wr), .data(len_data),
    .accept(accept), .take(take), .pend(pend), .len(plen)
  );

  ftx_clkstat u_cst (
    .clk(clk), .rst(rst), .bclk_ok(bclk_ok), .cpu_wr(clk_wr),
    .done(cdone), .done_val(mem_wdata[0]),
    .need(need), .val(cval), .quiet(quiet)
  );

  ftx_seq #(.DW(DW), .AW(AW), .FLAG(FLAG)) u_seq (
    .clk(clk), .rst(rst), .bclk_ok(bclk_ok),
    .start_pend(pend), .start_len(plen), .start_take(take), .tx_idle(accept),
    .clk_need(need), .clk_val(cval), .clk_quiet(quiet), .clk_done(cdone),
    .mem_req(mem_req), .mem_rwn(mem_rwn), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ser_wr(ser_wr), .ser_flag(ser_flag), .ser_data(ser_data),
    .ser_next(ser_next),
    .crc_clr(crc_clr), .crc_en(crc_en), .crc_din(crc_din),
    .crc_valid(crc_valid), .crc_val(crc_val), .irq(irq)
  );

  // R11: no activity while reset is held
  a_r11_quiet_in_reset: assert property (@(posedge clk)
    $past(rst) |-> !mem_req && !ser_wr && !irq && !crc_en && !crc_clr);
endmodule

// File: tb/sim_ftx_ctrl.sv
module sim_ftx_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        len_wr = 1'b0;
  logic [7:0]  len_data = 8'h00;
  logic        clk_wr = 1'b0;
  logic        bclk_ok = 1'b0;
  logic        mem_req, mem_rwn;
  logic [7:0]  mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = 8'h00;
  logic        ser_wr, ser_flag;
  logic [7:0]  ser_data;
  logic        ser_next = 1'b0;
  logic        crc_clr, crc_en;
  logic [7:0]  crc_din;
  logic        crc_valid = 1'b0;
  logic [15:0] crc_val = 16'h0000;
  logic        irq;

  ftx_ctrl u0 (
    .clk(clk), .rst(rst), .len_wr(len_wr), .len_data(len_data),
    .clk_wr(clk_wr), .bclk_ok(bclk_ok),
    .mem_req(mem_req), .mem_rwn(mem_rwn), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ser_wr(ser_wr), .ser_flag(ser_flag), .ser_data(ser_data),
    .ser_next(ser_next),
    .crc_clr(crc_clr), .crc_en(crc_en), .crc_din(crc_din),
    .crc_valid(crc_valid), .crc_val(crc_val), .irq(irq)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0;
  int nerr = 0;

  // len, seed, memory latency, serializer gap
  localparam int NVEC = 5;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h01_10_00_01, 32'h02_A5_01_03, 32'h05_3C_02_02,
    32'h11_00_03_05, 32'hFD_77_01_01
  };

  logic [7:0] mem [256];
  int lat = 1;
  int gap = 3;

  // models' logs
  logic [7:0] logb [300];
  logic       logf [300];
  logic [7:0] wlog [64];
  logic [7:0] clog [256];
  int nlog = 0, nw = 0, nff = 0, nfe = 0, nrd = 0, ncrc = 0, nclr = 0;
  int nirq = 0, sviol = 0, mviol = 0, first_cyc = 0;
  int mcnt = 0, scnt = 0;
  bit sbusy = 0;
  logic [7:0]  maddr_q = 8'h00;
  logic [15:0] creg = 16'h0000;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7);
  endfunction

  // memory model
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mcnt = 0;
    end else if (mem_req) begin
      if (mcnt > 0 && mem_addr != maddr_q) mviol++;
      maddr_q = mem_addr;
      if (mcnt >= lat) begin
        mem_ack = 1'b1;
        if (mem_rwn) begin
          mem_rdata = mem[mem_addr];
          nrd++;
        end else begin
          mem[mem_addr] = mem_wdata;
          if (nw < 64) wlog[nw] = mem_addr;
          nw++;
          if (mem_addr == 8'hFF) nff++;
          if (mem_addr == 8'hFE) nfe++;
        end
      end else mcnt++;
    end else mcnt = 0;
  end

  // serializer and CRC engine models, interrupt counter
  always @(negedge clk) begin
    if (ser_next) ser_next = 1'b0;
    if (ser_wr) begin
      if (sbusy) sviol++;
      if (nlog == 0) first_cyc = cyc;
      if (nlog < 300) begin
        logb[nlog] = ser_data;
        logf[nlog] = ser_flag;
      end
      nlog++;
      sbusy = 1'b1;
      scnt = gap;
    end else if (sbusy) begin
      if (scnt <= 1) begin
        ser_next = 1'b1;
        sbusy = 1'b0;
      end else scnt--;
    end
    if (crc_clr) begin
      creg = 16'h0000;
      crc_valid = 1'b0;
      nclr++;
    end else if (crc_en) begin
      if (ncrc < 256) clog[ncrc] = crc_din;
      ncrc++;
      creg = crc_step(creg, crc_din);
      crc_valid = 1'b0;
    end else crc_valid = 1'b1;
    crc_val = creg;
    if (irq) nirq++;
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    nlog = 0; nw = 0; nrd = 0; ncrc = 0; nclr = 0;
  endtask

  task automatic write_len(input logic [7:0] v);
    len_wr = 1'b1;
    len_data = v;
    step();
    len_wr = 1'b0;
  endtask

  task automatic wait_ff(input int target, input string req);
    int t = 0;
    while (nff < target && t < 20000) begin
      step();
      t++;
    end
    chk(nff >= target, req, nff, target);
    step(3);
  endtask

  task automatic check_frame(input int len, input logic [7:0] seed, input string req);
    logic [15:0] c = 16'h0000;
    int bad = -1;
    logic [7:0] expb;
    logic       expf;
    for (int i = 0; i < len; i++) c = crc_step(c, pat(seed, i));
    chk(nlog == len + 4, req, nlog, len + 4);
    for (int i = 0; i < len + 4 && i < nlog; i++) begin
      if (i == 0 || i == len + 3) begin expb = 8'h7E; expf = 1'b1; end
      else if (i == len + 1) begin expb = c[15:8]; expf = 1'b0; end
      else if (i == len + 2) begin expb = c[7:0]; expf = 1'b0; end
      else begin expb = pat(seed, i - 1); expf = 1'b0; end
      if (bad < 0 && (logb[i] !== expb || logf[i] !== expf)) begin
        bad = i;
        chk(1'b0, req, int'(logb[i]), int'(expb));
      end
    end
    if (bad < 0) chk(1'b1, req, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int irq0, ff0, fe0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    // R11 reset state
    step(3);
    chk(!mem_req && !ser_wr && !irq && !crc_en && !crc_clr, "R11 in reset",
        int'(mem_req) + int'(ser_wr) + int'(irq), 0);
    rst = 1'b0;
    step(20);
    chk(nirq == 0 && nw == 0 && nlog == 0, "R11 R7 idle with clock absent", nw + nirq, 0);

    // R7 clock appears
    bclk_ok = 1'b1;
    step(20);
    chk(mem[8'hFE] == 8'hFF && nfe == 1, "R7 status present written",
        int'(mem[8'hFE]), 255);
    chk(nirq == 1, "R7 irq on clock change", nirq, 1);

    // vector table: R1 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      int len, t0;
      logic [7:0] seed;
      len  = int'(VEC[v][31:24]);
      seed = VEC[v][23:16];
      lat  = int'(VEC[v][15:8]);
      gap  = int'(VEC[v][7:0]);
      for (int i = 0; i < 254; i++) mem[i] = pat(seed, i);
      mem[8'hFF] = 8'(len);
      clear_logs();
      irq0 = nirq;
      ff0  = nff;
      t0   = cyc;
      write_len(8'(len));
      wait_ff(ff0 + 1, "R6 completion write");
      check_frame(len, seed, "R1 R5 frame content");
      if (v == 0) chk(first_cyc - t0 == 2, "R3 first byte latency", first_cyc - t0, 2);
      begin
        int cbad = 0;
        for (int i = 0; i < len && i < ncrc; i++) if (clog[i] !== pat(seed, i)) cbad++;
        chk(ncrc == len && cbad == 0 && nclr == 1, "R5 crc feed count", ncrc, len);
      end
      chk(mem[8'hFF] == 8'hFF && nrd == len, "R6 R4 length overwritten, reads",
          int'(mem[8'hFF]), 255);
      chk(nirq == irq0 + 1, "R6 completion irq", nirq - irq0, 1);
    end
    chk(sviol == 0, "R3 byte only after next", sviol, 0);
    chk(mviol == 0, "R4 address held", mviol, 0);

    // R2 invalid lengths
    lat = 1;
    gap = 3;
    begin
      logic [7:0] badv [3] = '{8'h00, 8'hFE, 8'hFF};
      for (int k = 0; k < 3; k++) begin
        clear_logs();
        write_len(badv[k]);
        step(40);
        chk(nlog == 0 && nrd == 0 && nw == 0, "R2 invalid length ignored",
            nlog + nrd + nw, 0);
      end
    end

    // R2 write during a frame
    for (int i = 0; i < 16; i++) mem[i] = pat(8'h41, i);
    clear_logs();
    ff0 = nff;
    write_len(8'd4);
    while (nlog < 2) step();
    write_len(8'd9);
    wait_ff(ff0 + 1, "R2 busy frame completes");
    step(200);
    chk(nlog == 8 && nff == ff0 + 1, "R2 write while busy ignored", nlog, 8);

    // R8 quiet rewrite
    mem[8'hFE] = 8'h55;
    irq0 = nirq;
    fe0  = nfe;
    clk_wr = 1'b1;
    step();
    clk_wr = 1'b0;
    step(20);
    chk(mem[8'hFE] == 8'hFF && nfe == fe0 + 1, "R8 quiet rewrite value",
        int'(mem[8'hFE]), 255);
    chk(nirq == irq0, "R8 no irq on rewrite", nirq - irq0, 0);

    // R8 software write coinciding with genuine loss
    irq0 = nirq;
    fe0  = nfe;
    clk_wr = 1'b1;
    bclk_ok = 1'b0;
    step();
    clk_wr = 1'b0;
    step(30);
    chk(mem[8'hFE] == 8'h00 && nfe == fe0 + 1, "R8 coinciding change value",
        int'(mem[8'hFE]), 0);
    chk(nirq == irq0 + 1, "R8 coinciding change irq once", nirq - irq0, 1);

    // R9 length held while clock absent, status served first
    for (int i = 0; i < 8; i++) mem[i] = pat(8'h90, i);
    clear_logs();
    irq0 = nirq;
    ff0  = nff;
    write_len(8'd3);
    step(50);
    chk(nlog == 0 && nw == 0, "R9 no start without clock", nlog, 0);
    bclk_ok = 1'b1;
    wait_ff(ff0 + 1, "R9 held frame completes");
    chk(nw >= 1 && wlog[0] == 8'hFE, "R9 status write first", int'(wlog[0]), 254);
    check_frame(3, 8'h90, "R9 held frame content");
    chk(nirq == irq0 + 2, "R9 two irqs", nirq - irq0, 2);

    // R10 clock lost mid-frame
    for (int i = 0; i < 16; i++) mem[i] = pat(8'h22, i);
    gap = 4;
    clear_logs();
    irq0 = nirq;
    ff0  = nff;
    fe0  = nfe;
    write_len(8'd10);
    while (nlog < 4) step();
    bclk_ok = 1'b0;
    step(100);
    chk(nlog == 4, "R10 no byte after loss", nlog, 4);
    chk(nff == ff0, "R10 no completion write", nff - ff0, 0);
    chk(mem[8'hFE] == 8'h00 && nfe == fe0 + 1 && nirq == irq0 + 1,
        "R10 status update after abandon", nirq - irq0, 1);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule